// File: doc/BRIEF.md
# Parallel Port Control Register Unit

This block holds the host-visible control byte of an extended-capability parallel port. The host writes a byte to set the four printer control pins, the direction of the data bus drivers and the acknowledge interrupt enable. A host read returns the stored byte, with the two top bits fixed at one. The pin outputs are derived from the stored bits with fixed polarities. The data-direction output combines the stored direction bit with the port mode supplied by the surrounding port logic. Two modes are forward-only and force the output direction whatever the stored bit says.

The acknowledge input arrives from the cable without any timing relation to the clock. It passes through a synchronizer and a rising-edge detector. When interrupts are enabled, a detected rising edge sets a sticky interrupt flag. The flag stays set until the host reads the register or pulses a dedicated clear input. Clearing the enable bit also drops the flag.

All outputs come from flops. FIFOs, DMA and the transfer handshakes belong to neighbouring blocks.

Top module: `pport_ctl_unit`

## Requirements
- R1: Read data bits 7 and 6 are always 1. Host writes to those positions have no effect on readback or on any output.
- R2: A read strobe sampled at a clock edge loads host_rd_data at that edge with {2'b11, stored bits 5:0}. Stored bit 5 is returned even while the mode forces the direction. A write strobe stores host_wr_data[5:0] at its edge.
- R3: Synchronous reset has these effects:
  - stored bits 5:0 become 0 and host_rd_data becomes 8'hC0;
  - pin_strobe_n, pin_feed_n and pin_select_n go to 1;
  - pin_prime goes to 0;
  - dir_input and irq_out go to 0.
- R4: Direction is set by port_mode and stored bit 5:
  - port_mode 3'b000 or 3'b010 forces dir_input to 0 (output);
  - in every other mode dir_input equals stored bit 5, where 0 means output and 1 means input (mode 3'b011 included);
  - dir_input is registered and reflects the stored bit and mode one edge after they change.
- R5: The pin outputs are registered and take the new stored value one edge after the register changes:
  - pin_strobe_n = NOT bit 0;
  - pin_feed_n = NOT bit 1;
  - pin_prime = bit 2;
  - pin_select_n = NOT bit 3, so writing 1 selects the printer.
- R6: With stored bit 4 set, a low-to-high transition of ack_in sets irq_out. If ack_in changes just before edge k, irq_out rises after edge k+2. A falling edge or a steady level does not set it.
- R7: irq_out is sticky. It clears at the edge where host_rd_en or irq_clr is sampled high. If a new rising edge is detected at that same edge, the set wins.
- R8: While stored bit 4 is 0, no acknowledge edge sets irq_out, and a pending flag clears at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_data | input | 8 | Write data |
| host_rd_en | input | 1 | Register read strobe; also clears the interrupt flag |
| host_rd_data | output | 8 | Registered read data |
| port_mode | input | 3 | Current port mode from the port logic |
| irq_clr | input | 1 | Dedicated interrupt clear strobe |
| ack_in | input | 1 | Asynchronous acknowledge input from the cable |
| pin_strobe_n | output | 1 | Strobe pin, active low |
| pin_feed_n | output | 1 | Auto line-feed pin, active low |
| pin_prime | output | 1 | Printer initialise pin, passed through uninverted |
| pin_select_n | output | 1 | Select request pin, active low |
| dir_input | output | 1 | Data driver direction: 1 input, 0 output |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The stored byte changes at the edge that samples the write strobe. Read data is due at the edge that samples the read strobe. Pins and direction follow one edge after the stored byte. The bench therefore waits two falling edges after a write before it samples pins and direction, and one falling edge after a read strobe before it samples read data. The interrupt is due at the third edge after ack_in rises. The bench checks that irq_out is still low after two falling edges and high after the third. It also places a clear strobe exactly on that third edge to show that the set wins.

// File: rtl/pport_ctl_pkg.sv
package pport_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int STORE_W = REG_W - 2;

  // stored bit positions (host-visible layout)
  localparam int B_STROBE = 0;
  localparam int B_FEED   = 1;
  localparam int B_PRIME  = 2;
  localparam int B_SELECT = 3;
  localparam int B_IRQEN  = 4;
  localparam int B_DIR    = 5;

  localparam logic [2:0] MODE_STD  = 3'b000;
  localparam logic [2:0] MODE_FIFO = 3'b010;

  typedef struct packed {
    logic select_n;
    logic prime;
    logic feed_n;
    logic strobe_n;
  } pins_t;

  function automatic logic mode_forces_out(input logic [2:0] m);
    return (m == MODE_STD) || (m == MODE_FIFO);
  endfunction
endpackage

// File: rtl/pport_ack_sync.sv
module pport_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  // stage 0 samples the pin; the last stage is the delayed copy for edge detection
  generate
    for (genvar g = 0; g < SH_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pport_ctl_reg.sv
module pport_ctl_reg
  import pport_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  output logic [STORE_W-1:0] ctrl_q,
  output logic [REG_W-1:0]   rd_data
);
  localparam int FIX_W = REG_W - STORE_W;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data[STORE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= {{FIX_W{1'b1}}, {STORE_W{1'b0}}};
    else if (rd_en) rd_data <= {{FIX_W{1'b1}}, ctrl_q};
  end
endmodule

// File: rtl/pport_irq_latch.sv
module pport_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rise,
  input  logic clear,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (!enable) irq_q <= 1'b0;
    else if (rise)    irq_q <= 1'b1;
    else if (clear)   irq_q <= 1'b0;
  end
endmodule

// File: rtl/pport_pin_drv.sv
module pport_pin_drv
  import pport_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STORE_W-1:0] ctrl,
  input  logic [2:0]         mode,
  output pins_t              pins_q,
  output logic               dir_q
);
  pins_t pins_d;

  always_comb begin
    pins_d.strobe_n = ~ctrl[B_STROBE];
    pins_d.feed_n   = ~ctrl[B_FEED];
    pins_d.prime    =  ctrl[B_PRIME];
    pins_d.select_n = ~ctrl[B_SELECT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '{select_n: 1'b1, prime: 1'b0, feed_n: 1'b1, strobe_n: 1'b1};
      dir_q  <= 1'b0;
    end else begin
      pins_q <= pins_d;
      dir_q  <= mode_forces_out(mode) ? 1'b0 : ctrl[B_DIR];
    end
  end
endmodule

// File: rtl/pport_ctl_unit.sv
module pport_ctl_unit
  import pport_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr_en,
  input  logic [REG_W-1:0] host_wr_data,
  input  logic             host_rd_en,
  output logic [REG_W-1:0] host_rd_data,
  input  logic [2:0]       port_mode,
  input  logic             irq_clr,
  input  logic             ack_in,
  output logic             pin_strobe_n,
  output logic             pin_feed_n,
  output logic             pin_prime,
  output logic             pin_select_n,
  output logic             dir_input,
  output logic             irq_out
);
  logic [STORE_W-1:0] ctrl_q;
  logic               ack_rise;
  pins_t              pins;

  pport_ctl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr_en),
    .wr_data (host_wr_data),
    .rd_en   (host_rd_en),
    .ctrl_q  (ctrl_q),
    .rd_data (host_rd_data)
  );

  pport_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ack_in),
    .rise_o   (ack_rise)
  );

  pport_irq_latch u_irq (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl_q[B_IRQEN]),
    .rise   (ack_rise),
    .clear  (host_rd_en | irq_clr),
    .irq_q  (irq_out)
  );

  pport_pin_drv u_pins (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl_q),
    .mode   (port_mode),
    .pins_q (pins),
    .dir_q  (dir_input)
  );

  assign pin_strobe_n = pins.strobe_n;
  assign pin_feed_n   = pins.feed_n;
  assign pin_prime    = pins.prime;
  assign pin_select_n = pins.select_n;
endmodule

// File: rtl/pport_ctl_unit_chk.sv
module pport_ctl_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_rd_en,
  input logic [7:0] host_rd_data,
  input logic [2:0] port_mode,
  input logic       irq_clr,
  input logic       pin_strobe_n,
  input logic       pin_feed_n,
  input logic       pin_prime,
  input logic       pin_select_n,
  input logic       dir_input,
  input logic       irq_out,
  input logic [5:0] ctrl_q
);
  a_r1_top_bits_one: assert property (@(posedge clk) disable iff (rst)
    host_rd_data[7:6] == 2'b11);

  a_r3_reset_state: assert property (@(posedge clk)
    rst |=> (!irq_out && !dir_input && pin_strobe_n && pin_feed_n && pin_select_n && !pin_prime));

  a_r4_forced_out: assert property (@(posedge clk) disable iff (rst)
    (port_mode == 3'b000 || port_mode == 3'b010) |=> !dir_input);

  a_r4_follow_bit: assert property (@(posedge clk) disable iff (rst)
    !(port_mode == 3'b000 || port_mode == 3'b010) |=> (dir_input == $past(ctrl_q[5])));

  a_r5_strobe_pol: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_strobe_n == !$past(ctrl_q[0])));

  a_r5_feed_pol: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_feed_n == !$past(ctrl_q[1])));

  a_r5_prime_pol: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_prime == $past(ctrl_q[2])));

  a_r5_select_pol: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pin_select_n == !$past(ctrl_q[3])));

  a_r6_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(ctrl_q[4]));

  a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_out) |-> $past(irq_clr || host_rd_en || !ctrl_q[4]));

  a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[4] |=> !irq_out);
endmodule

bind pport_ctl_unit pport_ctl_unit_chk chk_i (.*);

// File: tb/pport_ctl_unit_tb_top.sv
module pport_ctl_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_wr_en, host_rd_en, irq_clr, ack_in;
  logic [7:0] host_wr_data, host_rd_data;
  logic [2:0] port_mode;
  logic       pin_strobe_n, pin_feed_n, pin_prime, pin_select_n, dir_input, irq_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [5:0] shadow = '0;

  always #5 clk = ~clk;

  pport_ctl_unit dut_i (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .port_mode(port_mode), .irq_clr(irq_clr), .ack_in(ack_in),
    .pin_strobe_n(pin_strobe_n), .pin_feed_n(pin_feed_n),
    .pin_prime(pin_prime), .pin_select_n(pin_select_n),
    .dir_input(dir_input), .irq_out(irq_out)
  );

  function automatic logic [3:0] pins_exp(input logic [5:0] r);
    return {~r[3], r[2], ~r[1], ~r[0]};
  endfunction

  function automatic logic dir_exp(input logic [2:0] m, input logic [5:0] r);
    return (m == 3'b000 || m == 3'b010) ? 1'b0 : r[5];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] m);
    host_wr_data = d;
    port_mode    = m;
    host_wr_en   = 1'b1;
    tick();
    host_wr_en = 1'b0;
    tick();
    shadow = d[5:0];
  endtask

  task automatic rd(output logic [7:0] v);
    host_rd_en = 1'b1;
    tick();
    host_rd_en = 1'b0;
    v = host_rd_data;
  endtask

  task automatic pin_chk(input string req);
    check(req, {4'h0, pin_select_n, pin_prime, pin_feed_n, pin_strobe_n}, {4'h0, pins_exp(shadow)});
    check(req, {7'h0, dir_input}, {7'h0, dir_exp(port_mode, shadow)});
  endtask

  task automatic ack_low();
    ack_in = 1'b0;
    repeat (3) tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    rst = 1'b1; host_wr_en = 0; host_rd_en = 0; irq_clr = 0; ack_in = 0;
    host_wr_data = '0; port_mode = 3'b001;
    repeat (3) tick();
    rst = 1'b0;
    // R3 reset state
    check("R3 pins", {4'h0, pin_select_n, pin_prime, pin_feed_n, pin_strobe_n}, 8'h0B);
    check("R3 dir", {7'h0, dir_input}, 8'h00);
    check("R3 irq", {7'h0, irq_out}, 8'h00);
    check("R3 rd_data", host_rd_data, 8'hC0);

    // R1 top bits ignored; R5 polarity
    wr(8'hC0, 3'b001);
    pin_chk("R1 pins unaffected by top bits");
    rd(v); check("R1 readback", v, 8'hC0);
    wr(8'h0F, 3'b001);
    pin_chk("R5 all pin bits set");
    rd(v); check("R2 readback 0F", v, 8'hCF);
    wr(8'h05, 3'b001);
    pin_chk("R5 alternate pins");

    // R4 direction forcing; R2 readback of forced bit
    wr(8'h20, 3'b000); pin_chk("R4 mode 000 forced out");
    check("R4 forced dir", {7'h0, dir_input}, 8'h00);
    rd(v); check("R2 dir bit while forced", v, 8'hE0);
    wr(8'h20, 3'b010); check("R4 mode 010 forced out", {7'h0, dir_input}, 8'h00);
    wr(8'h20, 3'b011); check("R4 mode 011 follows bit", {7'h0, dir_input}, 8'h01);
    wr(8'h00, 3'b011); check("R4 mode 011 output", {7'h0, dir_input}, 8'h00);
    wr(8'h20, 3'b001); check("R4 mode 001 follows bit", {7'h0, dir_input}, 8'h01);

    // R6 edge timing
    wr(8'h10, 3'b001);
    ack_in = 1'b1; tick(); tick();
    check("R6 irq not yet", {7'h0, irq_out}, 8'h00);
    tick();
    check("R6 irq after third edge", {7'h0, irq_out}, 8'h01);
    repeat (10) tick();
    check("R7 sticky", {7'h0, irq_out}, 8'h01);
    ack_low();
    check("R6 falling edge no effect", {7'h0, irq_out}, 8'h01);
    rd(v);
    check("R7 read clears", {7'h0, irq_out}, 8'h00);
    check("R2 readback enable", v, 8'hD0);
    repeat (5) tick();
    check("R6 steady level no set", {7'h0, irq_out}, 8'h00);

    // R7 dedicated clear
    ack_in = 1'b1; repeat (3) tick();
    check("R6 second rise", {7'h0, irq_out}, 8'h01);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R7 clear strobe", {7'h0, irq_out}, 8'h00);
    ack_low();

    // R7 set wins over coincident clear
    ack_in = 1'b1; tick(); tick();
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check("R7 set wins", {7'h0, irq_out}, 8'h01);
    ack_low();

    // R8 disable drops pending flag and blocks new ones
    wr(8'h00, 3'b001);
    check("R8 disable clears", {7'h0, irq_out}, 8'h00);
    ack_in = 1'b1; repeat (5) tick();
    check("R8 no set when disabled", {7'h0, irq_out}, 8'h00);
    ack_low();

    // random mix
    for (int i = 0; i < 150; i++) begin
      logic [7:0] d;
      logic [2:0] m;
      d = 8'($urandom);
      m = 3'($urandom);
      wr(d, m);
      pin_chk("R5 R4 random");
      rd(v);
      check("R2 R1 random readback", v, {2'b11, d[5:0]});
      check("R7 R8 irq idle", {7'h0, irq_out}, 8'h00);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule